// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block sits beside an asynchronous serial receiver and watches the same already-synchronized line. It does not decode data. It reports two line conditions as single-cycle strobes. A break is a low stretch that lasts at least one whole character time. An idle frame is a high stretch that lasts one whole character time. During a long high stretch the idle strobe repeats once per character time.

The character time in clocks comes from the programmed format. It is the number of clocks per bit multiplied by the sum of one start bit, the data bits, an optional parity bit and the stop time. The stop time can be a half bit, so the product is rounded up. A polarity control lets the block watch an inverted line.

The receiver gives a hint when it completes a character, together with the number of clocks since that character's start edge. The idle measurement then restarts from the nominal end of that character rather than from the moment the hint arrives. The break strobe is intended to send the paired receiver back to hunting for a start bit.

Top module: `line_cond_detector`

## Requirements
- R1: The character time is ceil(bit_clks × (1 + data_bits + parity_en + stop)), where stop_sel codes 0, 1, 2 and 3 mean 0, 0.5, 1 and 1.5 bit times.
- R2: A low run of N samples (after polarity correction) that ends with a high sample, where N is at least the character time, gives exactly one break strobe. The strobe appears in the cycle after the first high sample.
- R3: A low run shorter than the character time produces no break strobe.
- R4: With invert_i = 1, a high line_i level is treated as low and a low line_i level as high, for both break and idle.
- R5: Let sample t be the first high sample after a low. An idle strobe appears in the cycle after sample t + k·L for each k ≥ 1, where L is the character time, for as long as the line stays high. Over H high samples, floor((H−1)/L) idle strobes occur.
- R6: Any low sample cancels idle tracking. Counting restarts at the next high sample.
- R7: If frame_done_i is high with frame_age_i = A on a high sample d, the next idle strobe follows sample d + 2L − A.
- R8: A frame_done_i on the very sample where an idle strobe would be due suppresses that strobe, and the re-anchored timing of R7 applies.
- R9: The low-run counter saturates at its maximum, so a low run longer than the counter range still produces a break.
- R10: While rst_n is low, both strobes stay low. After reset the line is taken to have been high before the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronized serial line |
| invert_i | input | 1 | 1: line polarity is inverted |
| bit_clks_i | input | BITW_W | Clocks per bit (at least 1) |
| data_bits_i | input | DBITS_W | Data bits per character (5 to 9) |
| parity_en_i | input | 1 | 1: a parity bit is present |
| stop_sel_i | input | 2 | Stop time code: 0=none, 1=half, 2=one, 3=one and a half bits |
| frame_done_i | input | 1 | Receiver completed a character on this sample |
| frame_age_i | input | CNT_W | Clocks since that character's start edge |
| break_o | output | 1 | One-cycle break strobe |
| idle_o | output | 1 | One-cycle idle-frame strobe |

## Verification
Two functions can fall on the same sample: the idle threshold being reached, and the receiver's completion hint re-anchoring the idle count. The bench provokes this by raising frame_done_i on exactly the L-th high sample after a rise, with an age equal to L. It then checks that no strobe appears at that point and that the first strobe arrives exactly L samples later. A separate case places the hint early, with a smaller age, so that a design that ignores the re-anchor would strobe too soon.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    STOP_NONE     = 2'd0,
    STOP_HALF     = 2'd1,
    STOP_ONE      = 2'd2,
    STOP_ONE_HALF = 2'd3
  } stop_sel_e;

  // Character length in half-bit units: start, data, parity, then stop halves.
  function automatic int unsigned frame_halves(int unsigned data_bits,
                                               logic par_en,
                                               logic [1:0] stop_sel);
    return 2 * (1 + data_bits + 32'(par_en)) + 32'(stop_sel);
  endfunction

  // Halves times clocks-per-bit, divided by two and rounded up.
  function automatic int unsigned halves_to_clks(int unsigned halves,
                                                 int unsigned bit_clks);
    return (halves * bit_clks + 1) >> 1;
  endfunction

endpackage

// File: rtl/lcd_frame_len.sv
module lcd_frame_len #(
  parameter int BITW_W  = 12,
  parameter int DBITS_W = 4,
  parameter int CNT_W   = 20
) (
  input  logic [BITW_W-1:0]  bit_clks_i,
  input  logic [DBITS_W-1:0] data_bits_i,
  input  logic               par_en_i,
  input  logic [1:0]         stop_sel_i,
  output logic [CNT_W-1:0]   frame_clks_o
);
  import lcd_pkg::*;

  localparam logic [63:0] CNT_MAX = (64'd1 << CNT_W) - 64'd1;

  logic [63:0] full_w;

  assign full_w = 64'(halves_to_clks(frame_halves(32'(data_bits_i), par_en_i, stop_sel_i),
                                     32'(bit_clks_i)));

  always_comb begin
    if (full_w > CNT_MAX) frame_clks_o = '1;
    else                  frame_clks_o = full_w[CNT_W-1:0];
  end

endmodule

// File: rtl/lcd_break_track.sv
module lcd_break_track #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] frame_clks_i,
  output logic [CNT_W-1:0] low_cnt_o,
  output logic             break_o
);
  logic             armed_q;
  logic [CNT_W-1:0] low_cnt_q;

  assign low_cnt_o = low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      low_cnt_q <= '0;
      break_o   <= 1'b0;
    end else begin
      break_o <= rise_i && armed_q && (low_cnt_q >= frame_clks_i);
      if (fall_i) begin
        armed_q   <= 1'b1;
        low_cnt_q <= CNT_W'(1);
      end else if (rise_i) begin
        armed_q   <= 1'b0;
      end else if (!level_i && (low_cnt_q != '1)) begin
        low_cnt_q <= low_cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lcd_idle_track.sv
module lcd_idle_track #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] age_i,
  input  logic [CNT_W-1:0] frame_clks_i,
  output logic             due_o,
  output logic             idle_o
);
  localparam logic signed [CNT_W:0] ONE = 1;

  logic                    valid_q;
  logic signed [CNT_W:0]   since_q;
  logic signed [CNT_W:0]   next_w;
  logic signed [CNT_W:0]   len_w;
  logic signed [CNT_W:0]   anchor_w;

  assign len_w    = $signed({1'b0, frame_clks_i});
  assign next_w   = since_q + ONE;
  assign anchor_w = $signed({1'b0, age_i}) - len_w;
  assign due_o    = valid_q && level_i && !done_i && (next_w >= len_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      since_q <= '0;
      idle_o  <= 1'b0;
    end else begin
      idle_o <= due_o;
      if (!level_i) begin
        valid_q <= 1'b0;
        since_q <= '0;
      end else if (done_i) begin
        valid_q <= 1'b1;
        since_q <= anchor_w;
      end else if (!valid_q) begin
        valid_q <= 1'b1;
        since_q <= '0;
      end else if (due_o) begin
        since_q <= '0;
      end else begin
        since_q <= next_w;
      end
    end
  end

endmodule

// File: rtl/line_cond_detector.sv
module line_cond_detector #(
  parameter int BITW_W  = 12,
  parameter int DBITS_W = 4,
  parameter int CNT_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_i,
  input  logic               invert_i,
  input  logic [BITW_W-1:0]  bit_clks_i,
  input  logic [DBITS_W-1:0] data_bits_i,
  input  logic               parity_en_i,
  input  logic [1:0]         stop_sel_i,
  input  logic               frame_done_i,
  input  logic [CNT_W-1:0]   frame_age_i,
  output logic               break_o,
  output logic               idle_o
);
  logic             level_w;
  logic             level_q;
  logic             fall_w;
  logic             rise_w;
  logic             idle_due_w;
  logic [CNT_W-1:0] frame_clks_w;
  logic [CNT_W-1:0] low_cnt_w;

  assign level_w = line_i ^ invert_i;
  assign fall_w  = level_q & ~level_w;
  assign rise_w  = ~level_q & level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else        level_q <= level_w;
  end

  lcd_frame_len #(.BITW_W(BITW_W), .DBITS_W(DBITS_W), .CNT_W(CNT_W)) u_len (
    .bit_clks_i   (bit_clks_i),
    .data_bits_i  (data_bits_i),
    .par_en_i     (parity_en_i),
    .stop_sel_i   (stop_sel_i),
    .frame_clks_o (frame_clks_w)
  );

  lcd_break_track #(.CNT_W(CNT_W)) u_brk (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_i      (level_w),
    .fall_i       (fall_w),
    .rise_i       (rise_w),
    .frame_clks_i (frame_clks_w),
    .low_cnt_o    (low_cnt_w),
    .break_o      (break_o)
  );

  lcd_idle_track #(.CNT_W(CNT_W)) u_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .level_i      (level_w),
    .done_i       (frame_done_i),
    .age_i        (frame_age_i),
    .frame_clks_i (frame_clks_w),
    .due_o        (idle_due_w),
    .idle_o       (idle_o)
  );

endmodule

// File: rtl/lcd_checker.sv
module lcd_checker #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             level_w,
  input logic             rise_w,
  input logic             frame_done_i,
  input logic             idle_due_w,
  input logic [CNT_W-1:0] low_cnt_w,
  input logic [CNT_W-1:0] frame_clks_w,
  input logic             break_o,
  input logic             idle_o
);

  assert_break_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |=> !break_o);

  assert_break_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |-> $past(rise_w));

  assert_break_long_enough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    break_o |-> ($past(low_cnt_w) >= $past(frame_clks_w)));

  assert_idle_needs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(level_w));

  assert_idle_follows_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(idle_due_w));

  assert_done_blocks_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !$past(frame_done_i));

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(break_o && idle_o));

endmodule

bind line_cond_detector lcd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .level_w      (level_w),
  .rise_w       (rise_w),
  .frame_done_i (frame_done_i),
  .idle_due_w   (idle_due_w),
  .low_cnt_w    (low_cnt_w),
  .frame_clks_w (frame_clks_w),
  .break_o      (break_o),
  .idle_o       (idle_o)
);

// File: tb/tb_line_cond_detector.sv
module tb_line_cond_detector;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int DW = 4;
  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic          line;
  logic          invert;
  logic [BW-1:0] bit_clks;
  logic [DW-1:0] data_bits;
  logic          par_en;
  logic [1:0]    stop_sel;
  logic          done;
  logic [CW-1:0] age;
  logic          break_o;
  logic          idle_o;

  int checks = 0;
  int fails  = 0;
  int brk_seen = 0;
  int idl_seen = 0;
  bit lvl = 1'b1;

  line_cond_detector #(.BITW_W(BW), .DBITS_W(DW), .CNT_W(CW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line),
    .invert_i     (invert),
    .bit_clks_i   (bit_clks),
    .data_bits_i  (data_bits),
    .parity_en_i  (par_en),
    .stop_sel_i   (stop_sel),
    .frame_done_i (done),
    .frame_age_i  (age),
    .break_o      (break_o),
    .idle_o       (idle_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (break_o) brk_seen++;
    if (idle_o)  idl_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int db, input int pe, input int ss, input int bc);
    real r;
    r = (1.0 + db + pe + 0.5 * ss) * bc;
    return int'($ceil(r));
  endfunction

  task automatic set_lvl(input bit v);
    lvl  = v;
    line = v ^ invert;
  endtask

  // L low samples then H high samples; checks break and idle counts.
  task automatic pulse(input int L, input int H, input int len, input string btag,
                       input string itag);
    int b0 = 0;
    int i0 = 0;
    int eb;
    int ei;
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      set_lvl(1'b0);
      if (i == 0) begin b0 = brk_seen; i0 = idl_seen; end
    end
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      set_lvl(1'b1);
    end
    @(negedge clk);
    eb = (L >= len) ? 1 : 0;
    ei = (H - 1) / len;
    check((brk_seen - b0) == eb, btag, brk_seen - b0, eb);
    check((idl_seen - i0) == ei, itag, idl_seen - i0, ei);
  endtask

  task automatic config_fmt(input int db, input int pe, input int ss, input int bc);
    @(negedge clk);
    data_bits = db[DW-1:0];
    par_en    = pe[0];
    stop_sel  = ss[1:0];
    bit_clks  = bc[BW-1:0];
  endtask

  initial begin
    int len;
    int i0;
    rst_n = 1'b0; invert = 1'b0; line = 1'b0; lvl = 1'b0;
    done = 1'b0; age = '0;
    data_bits = 4'd8; par_en = 1'b0; stop_sel = 2'd2; bit_clks = 4'd1;
    // R10: strobes held low in reset, including a rise after a long low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!break_o && !idle_o, "R10 reset quiet", int'(break_o) + int'(idle_o), 0);
      if (i == 15) set_lvl(1'b1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    set_lvl(1'b1);

    // R1 R2 R3 R5 R6 sweep over formats
    for (int db = 5; db <= 9; db++)
      for (int pe = 0; pe <= 1; pe++)
        for (int ss = 0; ss <= 3; ss++)
          for (int bc = 1; bc <= 3; bc++) begin
            config_fmt(db, pe, ss, bc);
            len = exp_len(db, pe, ss, bc);
            pulse(len - 1, 2 * len + 1, len, "R1 R3 short low", "R5 idle repeat");
            pulse(len, len, len, "R1 R2 break at length", "R5 idle count");
            pulse(1, len, len, "R3 one-sample low", "R6 idle cancelled by low");
          end

    // R4: inverted polarity
    for (int ss = 0; ss <= 3; ss++) begin
      config_fmt(7, 1, ss, 2);
      len = exp_len(7, 1, ss, 2);
      @(negedge clk);
      invert = 1'b1;
      set_lvl(1'b1);
      pulse(len - 1, 2 * len + 1, len, "R4 inverted short low", "R4 inverted idle");
      pulse(len + 2, len, len, "R4 inverted break", "R4 inverted idle count");
      @(negedge clk);
      invert = 1'b0;
      set_lvl(1'b1);
    end

    // R9: saturation of the low counter (range 255, run 260)
    config_fmt(8, 1, 2, 3);
    len = exp_len(8, 1, 2, 3);
    pulse(260, 2, len, "R9 saturated long low", "R9 idle after long low");

    // R7: early completion hint with age len-3
    config_fmt(8, 0, 2, 2);
    len = exp_len(8, 0, 2, 2);
    @(negedge clk); set_lvl(1'b0); i0 = idl_seen;
    @(negedge clk); set_lvl(1'b0);
    @(negedge clk); set_lvl(1'b1);
    @(negedge clk);
    @(negedge clk); done = 1'b1; age = CW'(len - 3);
    @(negedge clk); done = 1'b0;
    for (int k = 1; k <= len + 2; k++) @(negedge clk);
    check((idl_seen - i0) == 0, "R7 no idle before re-anchored end", idl_seen - i0, 0);
    @(negedge clk);
    check((idl_seen - i0) == 1, "R7 idle at re-anchored end", idl_seen - i0, 1);

    // R8: completion hint on the sample where idle would be due
    @(negedge clk); set_lvl(1'b0); i0 = idl_seen;
    @(negedge clk); set_lvl(1'b0);
    @(negedge clk); set_lvl(1'b1);
    for (int k = 0; k < len; k++) @(negedge clk);
    done = 1'b1; age = CW'(len);
    @(negedge clk); done = 1'b0;
    check((idl_seen - i0) == 0, "R8 collision suppressed", idl_seen - i0, 0);
    for (int k = 1; k < len; k++) @(negedge clk);
    check((idl_seen - i0) == 0, "R8 no early idle", idl_seen - i0, 0);
    @(negedge clk);
    check((idl_seen - i0) == 1, "R8 idle one length later", idl_seen - i0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule